// File: doc/BRIEF.md
# Physical Address Memory Type Resolver

The resolver turns a physical address into an 8-bit memory type, using the range configuration that the surrounding logic holds. Three sources feed the configuration. A default-type control word carries a global enable, a fixed-range enable and a fallback type. A flat vector holds 88 fixed-range type bytes that cover the first megabyte of the address space. A set of `NUM_VAR` variable base/mask pairs covers the rest of the address space.

One address enters each cycle, and the type appears on `mem_type` one clock later. The decision order is as follows. The global enable comes first. Fixed-range decoding of the low megabyte comes second. The variable ranges come third, and all of them are compared in parallel. When several variable ranges hit, a precedence rule merges their types, so the order of the ranges never affects the result. When no variable range hits, the fallback type from the control word is used.

Top module: `mtr_resolver`

## Requirements
- R1: While `rst_n` is low at a rising edge, `mem_type` becomes 0 at that edge.
- R2: When bit 11 of `dflt_ctl` (global enable) is 0, the result is 0 (uncacheable) for every address and every configuration.
- R3: When bits 11 and 10 of `dflt_ctl` are both 1 and the address is below 0x80000, the result is fixed slot `addr>>16` (slots 0..7). Slot s is the byte `fixed_types[8s+7:8s]`.
- R4: With both enables set, an address from 0x80000 to 0xBFFFF uses fixed slot `8 + ((addr-0x80000)>>14)` (slots 8..23).
- R5: With both enables set, an address from 0xC0000 to 0xFFFFF uses fixed slot `24 + ((addr-0xC0000)>>12)` (slots 24..87). An address of 0x100000 or above never uses a fixed slot.
- R6: A fixed-slot hit takes priority over the variable ranges. When bit 10 of `dflt_ctl` is 0, the fixed slots have no effect and the low megabyte resolves like any other address.
- R7: Variable range i is active only when bit 11 of its mask word is 1. It hits when `addr & mask` equals `base & mask` on bits `ADDR_W-1:12`. Bits 11:0 of the address, base and mask take no part in the comparison. The type of range i is bits 7:0 of its base word. Range i occupies bits `[i*ADDR_W +: ADDR_W]` of `var_base` and `var_mask`.
- R8: When every hitting range carries the same type, that type is the result.
- R9: When any hitting range carries type 0 (uncacheable), the result is 0, whatever the other hits carry.
- R10: When the hits carry only types 4 (write-through) and 6 (write-back), and both types are present, the result is 4.
- R11: Any other mix of two or more distinct hit types gives 6 (write-back).
- R12: When global enable is set, no fixed slot applies, and no variable range hits, the result is `dflt_ctl[7:0]`.
- R13: The result for the inputs present at one rising edge appears on `mem_type` right after that edge and holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Physical address to resolve |
| dflt_ctl | input | 12 | Bit 11 global enable, bit 10 fixed-range enable, bits 7:0 fallback type |
| fixed_types | input | 704 | 88 fixed-range type bytes, slot s in bits 8s+7:8s |
| var_base | input | NUM_VAR*ADDR_W | Variable range bases, type in bits 7:0 of each word |
| var_mask | input | NUM_VAR*ADDR_W | Variable range masks, active flag in bit 11 of each word |
| mem_type | output | 8 | Resolved memory type, registered |

## Verification
The checker checks the following on every cycle:
- the forced-uncacheable result while global enable is off;
- the low-region fixed slot selection;
- the fallback type when nothing hits;
- the dominance of an uncacheable hit;
- the write-through outcome of a write-through/write-back mix.

Only the bench's scenarios can show the rest. That covers the exact slot boundaries of the 16 KB and 4 KB regions, and the effect of clearing the active bit or the fixed-range enable. It also covers insensitivity to the order of the ranges and the write-back fallback for undefined mixes. Randomized configurations compared against a model written from the requirements exercise all of these rules together.

// File: rtl/mtr_pkg.sv
// Package: shared constants for the memory type resolver.
// Assumes memory types are 8-bit codes and page granularity is 4 KB.
package mtr_pkg;
    localparam int TYPE_W      = 8;
    localparam int CTL_W       = 12;
    localparam int PAGE_SHIFT  = 12;
    localparam int FIXED_SLOTS = 88;
    localparam int FIXED_W     = FIXED_SLOTS * TYPE_W;
    localparam int SLOT_IDX_W  = $clog2(FIXED_SLOTS);
    localparam int GLOB_EN_BIT = 11;
    localparam int FIX_EN_BIT  = 10;
    localparam int VALID_BIT   = 11;

    localparam logic [TYPE_W-1:0] MT_UC = 8'd0;
    localparam logic [TYPE_W-1:0] MT_WT = 8'd4;
    localparam logic [TYPE_W-1:0] MT_WB = 8'd6;

    // True for the two types whose mix resolves to write-through.
    function automatic logic is_wt_or_wb(input logic [TYPE_W-1:0] t);
        return (t == MT_WT) || (t == MT_WB);
    endfunction
endpackage

// File: rtl/mtr_fixed_lookup.sv
// Fixed-range lookup: decodes the low megabyte into one of 88 slots
// (64 KB, 16 KB, then 4 KB granules) and returns that slot's type byte.
// Assumes ADDR_W > 20. The enable check is left to the caller.
module mtr_fixed_lookup
    import mtr_pkg::*;
#(
    parameter int ADDR_W = 36
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [FIXED_W-1:0] fixed_types,
    output logic               in_low_mb,
    output logic [TYPE_W-1:0]  slot_type
);
    logic [SLOT_IDX_W-1:0] slot;

    // Flags addresses below 0x100000.
    assign in_low_mb = (addr[ADDR_W-1:20] == '0);

    // Chooses the slot from the granule region the address falls in.
    always_comb begin
        if (!addr[19])
            slot = SLOT_IDX_W'({addr[18:16]});
        else if (!addr[18])
            slot = SLOT_IDX_W'(8) + SLOT_IDX_W'({addr[17:14]});
        else
            slot = SLOT_IDX_W'(24) + SLOT_IDX_W'({addr[17:12]});
    end

    // Selects the addressed byte out of the packed slot vector.
    assign slot_type = fixed_types[slot*TYPE_W +: TYPE_W];
endmodule

// File: rtl/mtr_var_match.sv
// Variable-range matcher: one comparator per range, all in parallel.
// Assumes the type lives in base[7:0] and the active flag in mask[11].
// Bits below page granularity are excluded from the comparison.
module mtr_var_match
    import mtr_pkg::*;
#(
    parameter int ADDR_W  = 36,
    parameter int NUM_VAR = 8
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NUM_VAR*ADDR_W-1:0] var_base,
    input  logic [NUM_VAR*ADDR_W-1:0] var_mask,
    output logic [NUM_VAR-1:0]        hit,
    output logic [NUM_VAR*TYPE_W-1:0] hit_type
);
    localparam int PG_W = ADDR_W - PAGE_SHIFT;

    for (genvar i = 0; i < NUM_VAR; i++) begin : g_range
        logic [ADDR_W-1:0] b;
        logic [ADDR_W-1:0] m;
        logic [PG_W-1:0]   pa, pb, pm;
        assign b  = var_base[i*ADDR_W +: ADDR_W];
        assign m  = var_mask[i*ADDR_W +: ADDR_W];
        assign pa = addr[ADDR_W-1:PAGE_SHIFT];
        assign pb = b[ADDR_W-1:PAGE_SHIFT];
        assign pm = m[ADDR_W-1:PAGE_SHIFT];
        // Compares the masked page numbers of an active range.
        assign hit[i] = m[VALID_BIT] && ((pa & pm) == (pb & pm));
        assign hit_type[i*TYPE_W +: TYPE_W] = b[TYPE_W-1:0];
    end
endmodule

// File: rtl/mtr_overlap_merge.sv
// Overlap merge: reduces the types of all hitting ranges to one type by
// precedence: same -> that type, any UC -> UC, WT+WB only -> WT, else WB.
// The result is independent of range order. Assumes NUM_VAR >= 1.
module mtr_overlap_merge
    import mtr_pkg::*;
#(
    parameter int NUM_VAR = 8
) (
    input  logic [NUM_VAR-1:0]        hit,
    input  logic [NUM_VAR*TYPE_W-1:0] hit_type,
    output logic                      any_hit,
    output logic [TYPE_W-1:0]         merged
);
    logic [TYPE_W-1:0] first_t;
    logic              all_same, has_uc, only_wtwb;

    // Picks a reference type from the lowest-index hit.
    always_comb begin
        any_hit = 1'b0;
        first_t = '0;
        for (int i = 0; i < NUM_VAR; i++) begin
            if (hit[i] && !any_hit) begin
                first_t = hit_type[i*TYPE_W +: TYPE_W];
                any_hit = 1'b1;
            end
        end
    end

    // Gathers the precedence flags over every hit.
    always_comb begin
        all_same  = 1'b1;
        has_uc    = 1'b0;
        only_wtwb = 1'b1;
        for (int i = 0; i < NUM_VAR; i++) begin
            if (hit[i]) begin
                if (hit_type[i*TYPE_W +: TYPE_W] != first_t) all_same = 1'b0;
                if (hit_type[i*TYPE_W +: TYPE_W] == MT_UC) has_uc = 1'b1;
                if (!is_wt_or_wb(hit_type[i*TYPE_W +: TYPE_W])) only_wtwb = 1'b0;
            end
        end
    end

    // Applies the precedence order to the flags.
    always_comb begin
        if (has_uc)         merged = MT_UC;
        else if (all_same)  merged = first_t;
        else if (only_wtwb) merged = MT_WT;
        else                merged = MT_WB;
    end
endmodule

// File: rtl/mtr_resolver.sv
// Memory type resolver top: global enable, then fixed slots in the low
// megabyte, then merged variable ranges, then the fallback type.
// The result is registered, so latency is one clock. Configuration is
// assumed stable or sampled together with the address.
module mtr_resolver
    import mtr_pkg::*;
#(
    parameter int ADDR_W  = 36,
    parameter int NUM_VAR = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [CTL_W-1:0]          dflt_ctl,
    input  logic [FIXED_W-1:0]        fixed_types,
    input  logic [NUM_VAR*ADDR_W-1:0] var_base,
    input  logic [NUM_VAR*ADDR_W-1:0] var_mask,
    output logic [TYPE_W-1:0]         mem_type
);
    logic                      in_low_mb;
    logic [TYPE_W-1:0]         slot_type;
    logic [NUM_VAR-1:0]        hit;
    logic [NUM_VAR*TYPE_W-1:0] hit_type;
    logic                      any_hit;
    logic [TYPE_W-1:0]         merged;
    logic [TYPE_W-1:0]         next_type;

    mtr_fixed_lookup #(.ADDR_W(ADDR_W)) u_fixed (
        .addr(addr), .fixed_types(fixed_types),
        .in_low_mb(in_low_mb), .slot_type(slot_type)
    );

    mtr_var_match #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR)) u_var (
        .addr(addr), .var_base(var_base), .var_mask(var_mask),
        .hit(hit), .hit_type(hit_type)
    );

    mtr_overlap_merge #(.NUM_VAR(NUM_VAR)) u_merge (
        .hit(hit), .hit_type(hit_type),
        .any_hit(any_hit), .merged(merged)
    );

    // Chooses the result source in order of priority.
    always_comb begin
        if (!dflt_ctl[GLOB_EN_BIT])                    next_type = MT_UC;
        else if (dflt_ctl[FIX_EN_BIT] && in_low_mb)    next_type = slot_type;
        else if (any_hit)                              next_type = merged;
        else                                           next_type = dflt_ctl[TYPE_W-1:0];
    end

    // Registers the result; reset forces uncacheable.
    always_ff @(posedge clk) begin
        if (!rst_n) mem_type <= MT_UC;
        else        mem_type <= next_type;
    end
endmodule

// File: rtl/mtr_resolver_chk.sv
// Checker for mtr_resolver: recomputes hit conditions from the ports and
// relates them to the registered result one cycle later.
module mtr_resolver_chk
    import mtr_pkg::*;
#(
    parameter int ADDR_W  = 36,
    parameter int NUM_VAR = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         addr,
    input logic [CTL_W-1:0]          dflt_ctl,
    input logic [FIXED_W-1:0]        fixed_types,
    input logic [NUM_VAR*ADDR_W-1:0] var_base,
    input logic [NUM_VAR*ADDR_W-1:0] var_mask,
    input logic [TYPE_W-1:0]         mem_type
);
    logic       en, fix_used, lo_region, any_m, uc_m, wt_m, wb_m, other_m;
    logic [7:0] lo_byte;

    // Independent view of which sources apply to this address.
    always_comb begin
        en        = dflt_ctl[11];
        fix_used  = dflt_ctl[10] && (addr < ADDR_W'(32'h100000));
        lo_region = en && dflt_ctl[10] && (addr < ADDR_W'(32'h80000));
        lo_byte   = fixed_types[addr[18:16]*8 +: 8];
        any_m = 1'b0; uc_m = 1'b0; wt_m = 1'b0; wb_m = 1'b0; other_m = 1'b0;
        for (int i = 0; i < NUM_VAR; i++) begin
            if (var_mask[i*ADDR_W+11] &&
                (((addr ^ var_base[i*ADDR_W +: ADDR_W]) &
                  var_mask[i*ADDR_W +: ADDR_W]) >> 12) == '0) begin
                any_m = 1'b1;
                case (var_base[i*ADDR_W +: 8])
                    8'd0:    uc_m = 1'b1;
                    8'd4:    wt_m = 1'b1;
                    8'd6:    wb_m = 1'b1;
                    default: other_m = 1'b1;
                endcase
            end
        end
    end

    assert_disabled_uc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(en) |-> mem_type == 8'd0);

    assert_low_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(lo_region) |-> mem_type == $past(lo_byte));

    assert_uc_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(en && !fix_used && uc_m) |-> mem_type == 8'd0);

    assert_wt_wb_mix_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(en && !fix_used && wt_m && wb_m && !uc_m && !other_m)
        |-> mem_type == 8'd4);

    assert_fallback_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(en && !fix_used && !any_m)
        |-> mem_type == $past(dflt_ctl[7:0]));
endmodule

bind mtr_resolver mtr_resolver_chk #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .dflt_ctl(dflt_ctl),
    .fixed_types(fixed_types), .var_base(var_base), .var_mask(var_mask),
    .mem_type(mem_type)
);

// File: tb/sim_mtr_resolver.sv
module sim_mtr_resolver;
    localparam int AW = 36;
    localparam int NV = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [11:0]     dflt_ctl = '0;
    logic [703:0]    fixed_types = '0;
    logic [NV*AW-1:0] var_base = '0;
    logic [NV*AW-1:0] var_mask = '0;
    logic [7:0]      mem_type;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    mtr_resolver #(.ADDR_W(AW), .NUM_VAR(NV)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .dflt_ctl(dflt_ctl),
        .fixed_types(fixed_types), .var_base(var_base), .var_mask(var_mask),
        .mem_type(mem_type)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [7:0] exp);
        checks++;
        if (mem_type !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual=%0d expected=%0d", req, addr, mem_type, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge register, sample at the next fall.
    task automatic look(input logic [AW-1:0] a, input string req, input logic [7:0] exp);
        addr = a;
        @(negedge clk);
        check(req, exp);
    endtask

    task automatic set_var(input int i, input logic [AW-1:0] b, input logic [AW-1:0] m);
        var_base[i*AW +: AW] = b;
        var_mask[i*AW +: AW] = m;
    endtask

    task automatic clear_vars();
        var_base = '0;
        var_mask = '0;
    endtask

    // Model written from the requirements.
    function automatic logic [7:0] ref_type(input logic [AW-1:0] a);
        int s; int n; logic [7:0] first; bit same, uc, ww;
        logic [AW-1:0] b, m;
        if (!dflt_ctl[11]) return 8'd0;
        if (dflt_ctl[10] && a < 36'h100000) begin
            if (a < 36'h80000)      s = int'(a / 65536);
            else if (a < 36'hC0000) s = 8 + int'((a - 36'h80000) / 16384);
            else                    s = 24 + int'((a - 36'hC0000) / 4096);
            return fixed_types[s*8 +: 8];
        end
        n = 0; first = 0; same = 1; uc = 0; ww = 1;
        for (int i = 0; i < NV; i++) begin
            b = var_base[i*AW +: AW];
            m = var_mask[i*AW +: AW];
            if (m[11] && (((a >> 12) & (m >> 12)) == ((b >> 12) & (m >> 12)))) begin
                if (n == 0) first = b[7:0];
                else if (b[7:0] != first) same = 0;
                if (b[7:0] == 0) uc = 1;
                if (b[7:0] != 4 && b[7:0] != 6) ww = 0;
                n++;
            end
        end
        if (n == 0) return dflt_ctl[7:0];
        if (uc) return 8'd0;
        if (same) return first;
        if (ww) return 8'd4;
        return 8'd6;
    endfunction

    task automatic t_reset();
        dflt_ctl = 12'hC06; addr = 36'h40000;
        for (int s = 0; s < 88; s++) fixed_types[s*8 +: 8] = 8'(s);
        repeat (3) @(negedge clk);
        check("R1", 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R13", 8'd4);
    endtask

    task automatic t_disabled();
        dflt_ctl = 12'h406;
        set_var(0, 36'h0_0000_0006, 36'hF_0000_0800);
        look(36'h40000, "R2", 8'd0);
        look(36'h0_1234_5000, "R2", 8'd0);
        clear_vars();
    endtask

    task automatic t_fixed();
        dflt_ctl = 12'hC05;
        look(36'h0,      "R3", 8'd0);
        look(36'h7FFFF,  "R3", 8'd7);
        look(36'h80000,  "R4", 8'd8);
        look(36'h9C000,  "R4", 8'd15);
        look(36'hBFFFF,  "R4", 8'd23);
        look(36'hC0000,  "R5", 8'd24);
        look(36'hD3000,  "R5", 8'd43);
        look(36'hFFFFF,  "R5", 8'd87);
        look(36'h100000, "R5", 8'd5);
    endtask

    task automatic t_fixed_priority();
        dflt_ctl = 12'hC05;
        set_var(0, 36'h0_0000_0001, 36'hF_FFF0_0800);
        look(36'h7FFFF, "R6", 8'd7);
        dflt_ctl = 12'h805;
        look(36'h7FFFF, "R6", 8'd1);
        clear_vars();
        look(36'h7FFFF, "R6", 8'd5);
    endtask

    task automatic t_var_match();
        dflt_ctl = 12'h802;
        set_var(3, 36'h0_4000_0005, 36'hF_C000_0FFF);
        look(36'h0_4000_0FFF, "R7", 8'd5);
        look(36'h0_7FFF_F123, "R7", 8'd5);
        look(36'h0_8000_0000, "R7", 8'd2);
        set_var(3, 36'h0_4000_0005, 36'hF_C000_0000);
        look(36'h0_4000_0FFF, "R7", 8'd2);
        clear_vars();
    endtask

    task automatic t_overlaps();
        dflt_ctl = 12'h802;
        set_var(1, 36'h0_0000_0005, 36'hF_0000_0800);
        set_var(6, 36'h0_0100_0005, 36'hF_FF00_0800);
        look(36'h0_0100_0000, "R8", 8'd5);
        set_var(6, 36'h0_0100_0000, 36'hF_FF00_0800);
        look(36'h0_0100_0000, "R9", 8'd0);
        set_var(1, 36'h0_0000_0000, 36'hF_0000_0800);
        set_var(6, 36'h0_0100_0006, 36'hF_FF00_0800);
        look(36'h0_0100_0000, "R9", 8'd0);
        set_var(1, 36'h0_0000_0006, 36'hF_0000_0800);
        set_var(6, 36'h0_0100_0004, 36'hF_FF00_0800);
        look(36'h0_0100_0000, "R10", 8'd4);
        set_var(1, 36'h0_0000_0004, 36'hF_0000_0800);
        set_var(6, 36'h0_0100_0006, 36'hF_FF00_0800);
        look(36'h0_0100_0000, "R10", 8'd4);
        set_var(1, 36'h0_0000_0001, 36'hF_0000_0800);
        look(36'h0_0100_0000, "R11", 8'd6);
        set_var(1, 36'h0_0000_0005, 36'hF_0000_0800);
        set_var(6, 36'h0_0100_0004, 36'hF_FF00_0800);
        look(36'h0_0100_0000, "R11", 8'd6);
        look(36'h0_0200_0000, "R8", 8'd5);
        clear_vars();
    endtask

    task automatic t_fallback();
        dflt_ctl = 12'hC01;
        set_var(2, 36'h0_1000_0006, 36'hF_F000_0800);
        look(36'h0_2000_0000, "R12", 8'd1);
        look(36'h200000, "R12", 8'd1);
        clear_vars();
    endtask

    task automatic t_random();
        logic [7:0] tl [5] = '{8'd0, 8'd1, 8'd4, 8'd5, 8'd6};
        logic [AW-1:0] probes [6] = '{36'h7FFFF, 36'h80000, 36'hBFFFF,
                                      36'hC0000, 36'hFFFFF, 36'h100000};
        logic [AW-1:0] a;
        for (int c = 0; c < 300; c++) begin
            dflt_ctl = {($urandom % 4 != 0), 1'($urandom), 2'b00, tl[$urandom % 5]};
            for (int s = 0; s < 88; s++) fixed_types[s*8 +: 8] = tl[$urandom % 5];
            for (int i = 0; i < NV; i++) begin
                int sz = 12 + int'($urandom % 11);
                logic [AW-1:0] m = ~((36'd1 << sz) - 36'd1);
                m[11] = ($urandom % 3 != 0);
                set_var(i, {12'd0, 12'($urandom), 4'd0, tl[$urandom % 5]}, m);
            end
            for (int k = 0; k < 10; k++) begin
                if (k < 6) a = probes[k];
                else       a = {12'd0, 24'($urandom)};
                look(a, "R9", ref_type(a));
            end
        end
        clear_vars();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_disabled();
        t_fixed();
        t_fixed_priority();
        t_var_match();
        t_overlaps();
        t_fallback();
        t_random();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule